// File: doc/BRIEF.md
# Latency-Matched Trigger Hit Selector

This block is the digital periphery for a pixel array in which every pixel owns one storage cell. When a pixel reports a hit, its cell records the value of the running timestamp. A trigger decision arrives a fixed number of timestamp ticks after the interaction. The block subtracts a programmable latency from the running timestamp and compares the result with every stored value. Only the cells whose stored timestamp equals that delayed value become triggered. All other hits are dropped once they are older than the latency window.

Triggered cells wait for readout. A priority scan, lowest row first and then lowest column, presents one triggered cell at a time on the data bus as row, column and stored timestamp. A read strobe consumes the presented cell and frees it, and the scan then moves on to the next triggered cell. Every cell sits in one of three states: free, armed (it holds a hit and waits for its trigger), or triggered.

Top module: `trig_hit_selector`

## Requirements
- R1: After reset, every cell is free and `rd_valid_o` is low.
- R2: A free cell that sees its `hit_i` bit high at a clock edge becomes armed and stores the value of `ts_i` sampled at that edge.
- R3: At an edge where `trig_i` is high, an armed cell whose stored timestamp equals `ts_i - latency_i` (modulo 2^TS_W) becomes triggered. It is then presented with its row, its column and its stored timestamp. A cell can only become triggered at an edge where `trig_i` is high.
- R4: A trigger whose delayed timestamp differs from a cell's stored value leaves that cell untriggered.
- R5: At any edge where `ts_i` minus the stored value (modulo 2^TS_W) is greater than `latency_i`, an armed cell is freed, and it can take a new hit at that same edge.
- R6: A hit on an armed cell that is neither freed nor read at that edge is dropped, and the stored timestamp is unchanged.
- R7: When a trigger and a new hit reach the same cell at the same edge, the trigger is evaluated against the hit already held. A free cell hit at that edge is not triggered by that trigger.
- R8: Among triggered cells, the one with the lowest row is presented first. Within that row, the lowest column is presented first. The flat cell index is row*NUM_COLS + column.
- R9: A read strobe while `rd_valid_o` is high frees the presented cell at that edge, so that cell is not presented again. A read strobe while `rd_valid_o` is low has no effect.
- R10: A triggered cell stays presented, with a stable row, column and timestamp, until it is read or a new trigger selects a higher-priority cell. It never expires.
- R11: Both the latency subtraction and the age comparison wrap modulo 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NUM_ROWS*NUM_COLS | One hit pulse per cell, flat index row*NUM_COLS+col |
| ts_i | input | TS_W | Running timestamp |
| latency_i | input | TS_W | Trigger latency in timestamp ticks |
| trig_i | input | 1 | Trigger pulse |
| rd_i | input | 1 | Read strobe that consumes the presented cell |
| rd_valid_o | output | 1 | A triggered cell is presented |
| rd_row_o | output | $clog2(NUM_ROWS) | Row of the presented cell |
| rd_col_o | output | $clog2(NUM_COLS) | Column of the presented cell |
| rd_ts_o | output | TS_W | Stored timestamp of the presented cell |

## Verification
The bench builds the block as 4 rows by 4 columns with a 6-bit timestamp. With this size, the three-cell priority order spans two rows, and the timestamp wraps after only 64 cycles, so a hit stored just before the wrap can be matched by a trigger just after it. The latency is varied between 0 and 10. This covers the same-edge trigger-and-hit case and the expiry of armed cells within a few cycles.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;

    // Occupancy of one storage cell.
    typedef enum logic [1:0] {
        CELL_FREE      = 2'd0,
        CELL_ARMED     = 2'd1,
        CELL_TRIGGERED = 2'd2
    } cell_state_e;

endpackage

// File: rtl/tsel_cell.sv
`timescale 1ns/1ps
module tsel_cell #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic            trig_i,
    input  logic            rd_clr_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic [TS_W-1:0] dly_ts_i,
    input  logic [TS_W-1:0] lat_i,
    output logic            trg_o,
    output logic [TS_W-1:0] ts_o
);
    import tsel_pkg::*;

    typedef struct packed {
        cell_state_e     st;
        logic [TS_W-1:0] ts;
    } cell_reg_t;

    cell_reg_t       cell_d, cell_q;
    logic [TS_W-1:0] age;
    logic            match;
    logic            stale;

    always_comb begin
        cell_d = cell_q;
        age    = ts_i - cell_q.ts;
        match  = (cell_q.ts == dly_ts_i);
        stale  = (age > lat_i);
        unique case (cell_q.st)
            CELL_FREE: begin
                if (hit_i) begin
                    cell_d.st = CELL_ARMED;
                    cell_d.ts = ts_i;
                end
            end
            CELL_ARMED: begin
                // the held hit is judged before any new hit is considered
                if (trig_i && match) begin
                    cell_d.st = CELL_TRIGGERED;
                end else if (stale) begin
                    cell_d.st = CELL_FREE;
                    if (hit_i) begin
                        cell_d.st = CELL_ARMED;
                        cell_d.ts = ts_i;
                    end
                end
            end
            CELL_TRIGGERED: begin
                if (rd_clr_i) begin
                    cell_d.st = CELL_FREE;
                    if (hit_i) begin
                        cell_d.st = CELL_ARMED;
                        cell_d.ts = ts_i;
                    end
                end
            end
            default: cell_d.st = CELL_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '{st: CELL_FREE, ts: '0};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign trg_o = (cell_q.st == CELL_TRIGGERED);
    assign ts_o  = cell_q.ts;

endmodule

// File: rtl/tsel_prio_pick.sv
`timescale 1ns/1ps
module tsel_prio_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/trig_hit_selector.sv
`timescale 1ns/1ps
module trig_hit_selector #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 8,
    parameter int TS_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_ROWS*NUM_COLS-1:0] hit_i,
    input  logic [TS_W-1:0]              ts_i,
    input  logic [TS_W-1:0]              latency_i,
    input  logic                         trig_i,
    input  logic                         rd_i,
    output logic                         rd_valid_o,
    output logic [$clog2(NUM_ROWS)-1:0]  rd_row_o,
    output logic [$clog2(NUM_COLS)-1:0]  rd_col_o,
    output logic [TS_W-1:0]              rd_ts_o
);
    localparam int NUM_CELLS = NUM_ROWS * NUM_COLS;
    localparam int ROW_W     = $clog2(NUM_ROWS);
    localparam int COL_W     = $clog2(NUM_COLS);

    logic [TS_W-1:0]      dly_ts;
    logic [NUM_CELLS-1:0] trg_flag;
    logic [TS_W-1:0]      cell_ts [NUM_CELLS];
    logic [NUM_ROWS-1:0]  row_any;
    logic [COL_W-1:0]     row_col [NUM_ROWS];
    logic [TS_W-1:0]      row_ts  [NUM_ROWS];
    logic                 rd_fire;

    assign dly_ts  = ts_i - latency_i;
    assign rd_fire = rd_i & rd_valid_o;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            logic rd_clr;
            assign rd_clr = rd_fire && (rd_row_o == ROW_W'(r)) && (rd_col_o == COL_W'(c));
            tsel_cell #(.TS_W(TS_W)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .hit_i    (hit_i[r*NUM_COLS+c]),
                .trig_i   (trig_i),
                .rd_clr_i (rd_clr),
                .ts_i     (ts_i),
                .dly_ts_i (dly_ts),
                .lat_i    (latency_i),
                .trg_o    (trg_flag[r*NUM_COLS+c]),
                .ts_o     (cell_ts[r*NUM_COLS+c])
            );
        end

        tsel_prio_pick #(.N(NUM_COLS), .W(COL_W)) u_row_pick (
            .req_i (trg_flag[r*NUM_COLS +: NUM_COLS]),
            .any_o (row_any[r]),
            .idx_o (row_col[r])
        );

        assign row_ts[r] = cell_ts[r*NUM_COLS + int'(row_col[r])];
    end

    tsel_prio_pick #(.N(NUM_ROWS), .W(ROW_W)) u_top_pick (
        .req_i (row_any),
        .any_o (rd_valid_o),
        .idx_o (rd_row_o)
    );

    assign rd_col_o = row_col[rd_row_o];
    assign rd_ts_o  = row_ts[rd_row_o];

endmodule

// File: rtl/trig_hit_selector_chk.sv
`timescale 1ns/1ps
module trig_hit_selector_chk #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 8,
    parameter int TS_W     = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        trig_i,
    input logic                        rd_i,
    input logic                        rd_valid_o,
    input logic [$clog2(NUM_ROWS)-1:0] rd_row_o,
    input logic [$clog2(NUM_COLS)-1:0] rd_col_o,
    input logic [TS_W-1:0]             rd_ts_o,
    input logic [NUM_ROWS-1:0]         row_any
);
    localparam logic [NUM_ROWS-1:0] ROW_ONE = NUM_ROWS'(1);

    // R1: nothing is presented on the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid_o);

    // R3: a cell only becomes presentable through a trigger
    a_r3_valid_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> $past(trig_i));

    // R8: the presented row is the lowest row holding a triggered cell
    a_r8_lowest_row: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (row_any[rd_row_o] &&
                        ((row_any & ((ROW_ONE << rd_row_o) - ROW_ONE)) == '0)));

    // R9: a consumed cell is not presented again on the next cycle
    a_r9_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rd_valid_o) |=> !(rd_valid_o && rd_row_o == $past(rd_row_o) &&
                                   rd_col_o == $past(rd_col_o)));

    // R10: triggered cells never vanish without a read
    a_r10_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_i) |=> rd_valid_o);

    // R10: without read and trigger the bus content is frozen
    a_r10_stable_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_i && !trig_i) |=>
            ($stable(rd_row_o) && $stable(rd_col_o) && $stable(rd_ts_o)));

endmodule

bind trig_hit_selector trig_hit_selector_chk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .TS_W     (TS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .rd_i       (rd_i),
    .rd_valid_o (rd_valid_o),
    .rd_row_o   (rd_row_o),
    .rd_col_o   (rd_col_o),
    .rd_ts_o    (rd_ts_o),
    .row_any    (row_any)
);

// File: tb/trig_hit_selector_tb.sv
`timescale 1ns/1ps
module trig_hit_selector_tb;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int TSW   = 6;
    localparam int CELLS = ROWS * COLS;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [CELLS-1:0]            hit_i = '0;
    logic [TSW-1:0]              ts_i = '0;
    logic [TSW-1:0]              latency_i = '0;
    logic                        trig_i = 1'b0;
    logic                        rd_i = 1'b0;
    logic                        rd_valid_o;
    logic [$clog2(ROWS)-1:0]     rd_row_o;
    logic [$clog2(COLS)-1:0]     rd_col_o;
    logic [TSW-1:0]              rd_ts_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trig_hit_selector #(.NUM_ROWS(ROWS), .NUM_COLS(COLS), .TS_W(TSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_i(ts_i), .latency_i(latency_i),
        .trig_i(trig_i), .rd_i(rd_i), .rd_valid_o(rd_valid_o), .rd_row_o(rd_row_o),
        .rd_col_o(rd_col_o), .rd_ts_o(rd_ts_o)
    );

    // one clock edge; pulses apply to that edge, then the timestamp advances
    task automatic cycle();
        @(posedge clk);
        #1;
        ts_i   = ts_i + 1'b1;
        hit_i  = '0;
        trig_i = 1'b0;
        rd_i   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wait_ts(input logic [TSW-1:0] t);
        while (ts_i != t) cycle();
    endtask

    task automatic chk_bus(input string req, input bit ev, input int er,
                           input int ec, input int ets);
        checks++;
        if (ev) begin
            if (!(rd_valid_o && rd_row_o == er && rd_col_o == ec && rd_ts_o == ets)) begin
                errors++;
                $display("FAIL %s: got v=%0d r=%0d c=%0d ts=%0d, expected v=1 r=%0d c=%0d ts=%0d",
                         req, rd_valid_o, rd_row_o, rd_col_o, rd_ts_o, er, ec, ets);
            end
        end else if (rd_valid_o) begin
            errors++;
            $display("FAIL %s: got v=1 r=%0d c=%0d ts=%0d, expected v=0",
                     req, rd_row_o, rd_col_o, rd_ts_o);
        end
    endtask

    task automatic t_reset();
        chk_bus("R1 reset idle", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        logic [TSW-1:0] t;
        latency_i = 6'd5;
        t = ts_i;
        hit_i[6] = 1'b1; cycle();
        wait_ts(t + 6'd5);
        trig_i = 1'b1; cycle();
        chk_bus("R2 R3 matched cell presented", 1, 1, 2, int'(t));
        rd_i = 1'b1; cycle();
        chk_bus("R9 read frees cell", 0, 0, 0, 0);
        idle(12);
    endtask

    task automatic t_mismatch();
        logic [TSW-1:0] t;
        latency_i = 6'd5;
        t = ts_i;
        hit_i[3] = 1'b1; cycle();
        wait_ts(t + 6'd4);
        trig_i = 1'b1; cycle();
        chk_bus("R4 early trigger ignored", 0, 0, 0, 0);
        trig_i = 1'b1; cycle();
        chk_bus("R3 trigger at latency", 1, 0, 3, int'(t));
        rd_i = 1'b1; cycle();
        idle(12);
    endtask

    task automatic t_busy();
        logic [TSW-1:0] t;
        latency_i = 6'd4;
        t = ts_i;
        hit_i[5] = 1'b1; cycle();
        hit_i[5] = 1'b1; cycle();
        wait_ts(t + 6'd4);
        trig_i = 1'b1; cycle();
        chk_bus("R6 second hit dropped, first ts kept", 1, 1, 1, int'(t));
        rd_i = 1'b1; cycle();
        // second variant: trigger timed for the dropped hit finds nothing
        t = ts_i;
        hit_i[5] = 1'b1; cycle();
        hit_i[5] = 1'b1; cycle();
        wait_ts(t + 6'd5);
        trig_i = 1'b1; cycle();
        chk_bus("R6 dropped hit never triggers", 0, 0, 0, 0);
        idle(12);
    endtask

    task automatic t_expire();
        logic [TSW-1:0] t, t2;
        latency_i = 6'd3;
        t = ts_i;
        hit_i[0] = 1'b1; cycle();
        wait_ts(t + 6'd4);
        // age 4 > 3: freed at this edge, new hit accepted at the same edge
        t2 = ts_i;
        hit_i[0] = 1'b1; cycle();
        wait_ts(t2 + 6'd3);
        trig_i = 1'b1; cycle();
        chk_bus("R5 expired cell reloaded", 1, 0, 0, int'(t2));
        rd_i = 1'b1; cycle();
        chk_bus("R5 after read", 0, 0, 0, 0);
        idle(12);
    endtask

    task automatic t_coincide();
        logic [TSW-1:0] t, t2;
        latency_i = 6'd4;
        t = ts_i;
        hit_i[9] = 1'b1; cycle();
        wait_ts(t + 6'd4);
        t2 = ts_i;
        trig_i = 1'b1; hit_i[9] = 1'b1; cycle();
        chk_bus("R7 held hit judged first", 1, 2, 1, int'(t));
        rd_i = 1'b1; cycle();
        wait_ts(t2 + 6'd4);
        trig_i = 1'b1; cycle();
        chk_bus("R7 coinciding hit dropped", 0, 0, 0, 0);
        idle(12);
        latency_i = 6'd0;
        trig_i = 1'b1; hit_i[2] = 1'b1; cycle();
        chk_bus("R7 same-edge hit not triggered", 0, 0, 0, 0);
        idle(4);
    endtask

    task automatic t_priority();
        logic [TSW-1:0] t;
        latency_i = 6'd4;
        t = ts_i;
        hit_i[13] = 1'b1; hit_i[6] = 1'b1; hit_i[5] = 1'b1; cycle();
        wait_ts(t + 6'd4);
        trig_i = 1'b1; cycle();
        chk_bus("R8 first row1 col1", 1, 1, 1, int'(t));
        rd_i = 1'b1; cycle();
        chk_bus("R8 second row1 col2", 1, 1, 2, int'(t));
        rd_i = 1'b1; cycle();
        chk_bus("R8 third row3 col1", 1, 3, 1, int'(t));
        rd_i = 1'b1; cycle();
        chk_bus("R9 all consumed", 0, 0, 0, 0);
        idle(12);
    endtask

    task automatic t_hold_and_idle_read();
        logic [TSW-1:0] t;
        latency_i = 6'd2;
        rd_i = 1'b1; cycle();
        chk_bus("R9 read with nothing presented", 0, 0, 0, 0);
        t = ts_i;
        hit_i[7] = 1'b1; cycle();
        wait_ts(t + 6'd2);
        trig_i = 1'b1; cycle();
        idle(70);
        chk_bus("R10 triggered cell kept past wrap", 1, 1, 3, int'(t));
        rd_i = 1'b1; cycle();
        idle(12);
    endtask

    task automatic t_wrap();
        latency_i = 6'd10;
        wait_ts(6'd60);
        hit_i[15] = 1'b1; cycle();
        wait_ts(6'd5);
        trig_i = 1'b1; cycle();
        chk_bus("R11 early trigger across wrap", 0, 0, 0, 0);
        trig_i = 1'b1; cycle();
        chk_bus("R11 match across wrap", 1, 3, 3, 60);
        rd_i = 1'b1; cycle();
        idle(12);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_mismatch();
        t_busy();
        t_expire();
        t_coincide();
        t_priority();
        t_hold_and_idle_read();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule